// File: doc/BRIEF.md
# Conditional Branch Target Unit

This block settles where a 32-bit processor with 16-bit instruction parcels fetches next after a control-transfer instruction. Each request carries the address of the current instruction, the decoded fields of that instruction, a register operand, and the current arithmetic flags (zero, sign, carry, overflow and saturation). The unit returns the next fetch address, whether the transfer was taken, a link address for calls, and a trap request.

It handles four kinds of transfer:
- conditional short branches with a 9-bit displacement split over two fields,
- 22-bit relative jumps,
- 22-bit relative jumps that also produce a link address,
- jumps through a register.

An always-taken short branch whose displacement is zero would spin on itself forever. The unit turns that case into a trap request instead of a branch.

Requests enter on a valid/ready stream and results leave on a second valid/ready stream through one output register.
- A request is accepted on a clock edge where `req_valid` and `req_ready` are both high.
- `req_ready` is high whenever the output register is empty or its result is being consumed in the same cycle.
- While `rsp_valid` is high and `rsp_ready` is low, the result is held unchanged and no new request is accepted.
- The flags are sampled together with the request.

Top module: `flow_redirect_unit`

## Requirements
- R1: An accepted request yields `rsp_valid` high on the following cycle. `req_ready` equals `!rsp_valid || rsp_ready`.
- R2: While `rsp_valid` is high and `rsp_ready` is low, every result output keeps its value and `rsp_valid` stays high.
- R3: The short displacement puts `req_sdisp_hi` at bits 8..4 and `req_sdisp_lo` at bits 3..1, forces bit 0 to zero, and sign-extends from bit 8.
- R4: The condition code selects the test:
  - Codes 0, 1, 2, 3, 4, 6 and 7 test, in that order: overflow, carry, zero, carry-or-zero, sign, sign-xor-overflow, and (sign-xor-overflow)-or-zero.
  - Codes 8, 9, 10, 11, 12, 14 and 15 are the inverses of the code 8 below each of them.
  - Code 5 is always true.
  - Code 13 tests the saturation flag.
- R5: `req_kind` = 0 is a short branch. When taken, `rsp_next_pc` is pc + displacement. When not taken, it is pc + 2. `rsp_link` is 0.
- R6: When a short branch has code 5 and both displacement fields are zero, `rsp_trap` = 1, `rsp_taken` = 0 and `rsp_next_pc` = pc + 2. No other case raises `rsp_trap`.
- R7: `req_kind` = 1 is a long jump to pc + D.
  - D puts `req_ldisp_hi` at bits 21..16 and `req_ldisp_lo` at bits 15..1, forces bit 0 to zero, and sign-extends from bit 21.
  - The jump is always taken, and `rsp_link` is 0.
- R8: `req_kind` = 2 jumps to the same target as R7, is taken, and sets `rsp_link` = pc + 4.
- R9: `req_kind` = 3 jumps to `req_reg` with bit 0 cleared, is taken, and sets `rsp_link` = 0.
- R10: During reset, `rsp_valid`, `rsp_taken`, `rsp_trap`, `rsp_next_pc` and `rsp_link` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be accepted |
| req_kind | input | 2 | Transfer kind: 0 short, 1 long, 2 long with link, 3 register |
| req_pc | input | 32 | Address of the current instruction |
| req_cc | input | 4 | Condition code of a short branch |
| req_sdisp_hi | input | 5 | Upper short displacement field |
| req_sdisp_lo | input | 3 | Lower short displacement field |
| req_ldisp_hi | input | 6 | Upper long displacement field (first parcel) |
| req_ldisp_lo | input | 15 | Lower long displacement field (second parcel) |
| req_reg | input | 32 | Register operand for indirect jumps |
| flag_z | input | 1 | Zero flag |
| flag_s | input | 1 | Sign flag |
| flag_cy | input | 1 | Carry flag |
| flag_ov | input | 1 | Overflow flag |
| flag_sat | input | 1 | Saturation flag |
| rsp_valid | output | 1 | Result present |
| rsp_ready | input | 1 | Result consumed |
| rsp_next_pc | output | 32 | Next fetch address |
| rsp_taken | output | 1 | Transfer taken |
| rsp_link | output | 32 | Return address for linked jumps, else zero |
| rsp_trap | output | 1 | Self-loop branch trap request |

## Verification
Every result appears exactly one clock edge after the edge that accepts its request, because only the output register lies on the path.

The bench drives each request just after a falling edge and lets the next rising edge accept it. It then reads all four results at the following falling edge, which is half a cycle after they have settled.

For back-pressure, the bench holds `rsp_ready` low for several cycles and checks at each falling edge that the first result stays unchanged and that `req_ready` stays low. It then releases `rsp_ready` and checks that the queued request arrives one edge after its acceptance.

// File: rtl/flow_redirect_pkg.sv
package flow_redirect_pkg;
  localparam int ADDR_W   = 32;
  localparam int SHORT_W  = 9;
  localparam int LONG_W   = 22;
  localparam int SHI_W    = SHORT_W - 4;
  localparam int SLO_W    = 3;
  localparam int LLO_W    = 15;
  localparam int LHI_W    = LONG_W - LLO_W - 1;
  localparam int PARCEL_B = 2;

  typedef enum logic [1:0] {
    XFER_SHORT = 2'd0,
    XFER_LONG  = 2'd1,
    XFER_LINK  = 2'd2,
    XFER_REG   = 2'd3
  } xfer_kind_e;

  typedef struct packed {
    logic z;
    logic s;
    logic cy;
    logic ov;
    logic sat;
  } flags_t;
endpackage

// File: rtl/flow_cond_eval.sv
module flow_cond_eval
  import flow_redirect_pkg::*;
(
  input  logic [3:0] cc,
  input  flags_t     fl,
  output logic       hit
);
  logic base;
  logic lt;

  always_comb begin
    lt = fl.s ^ fl.ov;
    unique case (cc[2:0])
      3'd0: base = fl.ov;
      3'd1: base = fl.cy;
      3'd2: base = fl.z;
      3'd3: base = fl.cy | fl.z;
      3'd4: base = fl.s;
      3'd5: base = 1'b1;
      3'd6: base = lt;
      default: base = lt | fl.z;
    endcase
    if (cc == 4'd13)
      hit = fl.sat;
    else
      hit = base ^ cc[3];
  end
endmodule

// File: rtl/flow_target_calc.sv
module flow_target_calc
  import flow_redirect_pkg::*;
#(
  parameter int AW = ADDR_W
) (
  input  xfer_kind_e          kind,
  input  logic [AW-1:0]       pc,
  input  logic [3:0]          cc,
  input  logic [SHI_W-1:0]    sdisp_hi,
  input  logic [SLO_W-1:0]    sdisp_lo,
  input  logic [LHI_W-1:0]    ldisp_hi,
  input  logic [LLO_W-1:0]    ldisp_lo,
  input  logic [AW-1:0]       reg_val,
  input  logic                cond_hit,
  output logic [AW-1:0]       next_pc,
  output logic                taken,
  output logic [AW-1:0]       link,
  output logic                trap
);
  logic [SHORT_W-1:0] sdisp;
  logic [LONG_W-1:0]  ldisp;
  logic [AW-1:0]      sdisp_x;
  logic [AW-1:0]      ldisp_x;
  logic [AW-1:0]      seq_short;
  logic [AW-1:0]      seq_long;
  logic               self_loop;

  assign sdisp     = {sdisp_hi, sdisp_lo, 1'b0};
  assign ldisp     = {ldisp_hi, ldisp_lo, 1'b0};
  assign sdisp_x   = {{(AW-SHORT_W){sdisp[SHORT_W-1]}}, sdisp};
  assign ldisp_x   = {{(AW-LONG_W){ldisp[LONG_W-1]}}, ldisp};
  assign seq_short = pc + AW'(PARCEL_B);
  assign seq_long  = pc + AW'(2 * PARCEL_B);
  assign self_loop = (cc == 4'd5) && (sdisp_hi == '0) && (sdisp_lo == '0);

  always_comb begin
    next_pc = seq_short;
    taken   = 1'b0;
    link    = '0;
    trap    = 1'b0;
    unique case (kind)
      XFER_SHORT: begin
        if (self_loop) begin
          trap = 1'b1;
        end else if (cond_hit) begin
          taken   = 1'b1;
          next_pc = pc + sdisp_x;
        end
      end
      XFER_LONG: begin
        taken   = 1'b1;
        next_pc = pc + ldisp_x;
      end
      XFER_LINK: begin
        taken   = 1'b1;
        next_pc = pc + ldisp_x;
        link    = seq_long;
      end
      default: begin
        taken   = 1'b1;
        next_pc = {reg_val[AW-1:1], 1'b0};
      end
    endcase
  end
endmodule

// File: rtl/flow_redirect_unit.sv
module flow_redirect_unit
  import flow_redirect_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 req_valid,
  output logic                 req_ready,
  input  logic [1:0]           req_kind,
  input  logic [ADDR_W-1:0]    req_pc,
  input  logic [3:0]           req_cc,
  input  logic [SHI_W-1:0]     req_sdisp_hi,
  input  logic [SLO_W-1:0]     req_sdisp_lo,
  input  logic [LHI_W-1:0]     req_ldisp_hi,
  input  logic [LLO_W-1:0]     req_ldisp_lo,
  input  logic [ADDR_W-1:0]    req_reg,
  input  logic                 flag_z,
  input  logic                 flag_s,
  input  logic                 flag_cy,
  input  logic                 flag_ov,
  input  logic                 flag_sat,
  output logic                 rsp_valid,
  input  logic                 rsp_ready,
  output logic [ADDR_W-1:0]    rsp_next_pc,
  output logic                 rsp_taken,
  output logic [ADDR_W-1:0]    rsp_link,
  output logic                 rsp_trap
);
  flags_t              fl;
  logic                hit;
  logic [ADDR_W-1:0]   c_next;
  logic [ADDR_W-1:0]   c_link;
  logic                c_taken;
  logic                c_trap;

  assign fl = '{z: flag_z, s: flag_s, cy: flag_cy, ov: flag_ov, sat: flag_sat};
  assign req_ready = !rsp_valid || rsp_ready;

  flow_cond_eval u_cond (
    .cc  (req_cc),
    .fl  (fl),
    .hit (hit)
  );

  flow_target_calc #(.AW(ADDR_W)) u_tgt (
    .kind     (xfer_kind_e'(req_kind)),
    .pc       (req_pc),
    .cc       (req_cc),
    .sdisp_hi (req_sdisp_hi),
    .sdisp_lo (req_sdisp_lo),
    .ldisp_hi (req_ldisp_hi),
    .ldisp_lo (req_ldisp_lo),
    .reg_val  (req_reg),
    .cond_hit (hit),
    .next_pc  (c_next),
    .taken    (c_taken),
    .link     (c_link),
    .trap     (c_trap)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid   <= 1'b0;
      rsp_next_pc <= '0;
      rsp_taken   <= 1'b0;
      rsp_link    <= '0;
      rsp_trap    <= 1'b0;
    end else if (req_ready) begin
      rsp_valid <= req_valid;
      if (req_valid) begin
        rsp_next_pc <= c_next;
        rsp_taken   <= c_taken;
        rsp_link    <= c_link;
        rsp_trap    <= c_trap;
      end
    end
  end
endmodule

// File: rtl/flow_redirect_checker.sv
module flow_redirect_checker
  import flow_redirect_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic [1:0]        req_kind,
  input logic [ADDR_W-1:0] req_pc,
  input logic [ADDR_W-1:0] req_reg,
  input logic              rsp_valid,
  input logic              rsp_ready,
  input logic [ADDR_W-1:0] rsp_next_pc,
  input logic              rsp_taken,
  input logic [ADDR_W-1:0] rsp_link,
  input logic              rsp_trap
);
  logic accept;
  assign accept = req_valid && req_ready;

  a_r1_accept_valid: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> rsp_valid);

  a_r2_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_next_pc) && $stable(rsp_taken)
                                   && $stable(rsp_link) && $stable(rsp_trap)));

  a_r6_trap_not_taken: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_trap) |-> !rsp_taken);

  a_r8_link_addr: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && req_kind == 2'd2) |=> (rsp_taken && rsp_link == $past(req_pc) + 32'd4));

  a_r9_reg_target: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && req_kind == 2'd3) |=> (rsp_taken && rsp_next_pc == {$past(req_reg[ADDR_W-1:1]), 1'b0}));

  a_r10_reset_idle: assert property (@(posedge clk)
    !rst_n |-> (!rsp_valid && !rsp_trap && !rsp_taken));
endmodule

bind flow_redirect_unit flow_redirect_checker u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .req_valid   (req_valid),
  .req_ready   (req_ready),
  .req_kind    (req_kind),
  .req_pc      (req_pc),
  .req_reg     (req_reg),
  .rsp_valid   (rsp_valid),
  .rsp_ready   (rsp_ready),
  .rsp_next_pc (rsp_next_pc),
  .rsp_taken   (rsp_taken),
  .rsp_link    (rsp_link),
  .rsp_trap    (rsp_trap)
);

// File: tb/flow_redirect_unit_test.sv
module flow_redirect_unit_test;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 5000;

  typedef struct packed {
    logic [3:0]  cc;
    logic [4:0]  fl;      // {sat, ov, cy, s, z}
    logic [4:0]  dh;
    logic [2:0]  dl;
    logic        tk;
    logic        tr;
    logic [31:0] npc;
  } vec_t;

  localparam int NV = 23;
  localparam vec_t TBL [NV] = '{
    '{4'h2, 5'b00001, 5'h01, 3'd2, 1'b1, 1'b0, 32'h0000_1014},
    '{4'hA, 5'b00001, 5'h01, 3'd2, 1'b0, 1'b0, 32'h0000_1002},
    '{4'h6, 5'b00010, 5'h1F, 3'd7, 1'b1, 1'b0, 32'h0000_0FFE},
    '{4'hE, 5'b01010, 5'h10, 3'd0, 1'b1, 1'b0, 32'h0000_0F00},
    '{4'h7, 5'b00000, 5'h01, 3'd0, 1'b0, 1'b0, 32'h0000_1002},
    '{4'hF, 5'b00000, 5'h00, 3'd4, 1'b1, 1'b0, 32'h0000_1008},
    '{4'h3, 5'b00100, 5'h02, 3'd0, 1'b1, 1'b0, 32'h0000_1020},
    '{4'hB, 5'b00100, 5'h02, 3'd0, 1'b0, 1'b0, 32'h0000_1002},
    '{4'hD, 5'b10000, 5'h00, 3'd3, 1'b1, 1'b0, 32'h0000_1006},
    '{4'hD, 5'b00000, 5'h00, 3'd3, 1'b0, 1'b0, 32'h0000_1002},
    '{4'h0, 5'b01000, 5'h00, 3'd2, 1'b1, 1'b0, 32'h0000_1004},
    '{4'h8, 5'b01000, 5'h00, 3'd2, 1'b0, 1'b0, 32'h0000_1002},
    '{4'h1, 5'b00100, 5'h04, 3'd0, 1'b1, 1'b0, 32'h0000_1040},
    '{4'h9, 5'b00000, 5'h00, 3'd6, 1'b1, 1'b0, 32'h0000_100C},
    '{4'h4, 5'b00000, 5'h01, 3'd0, 1'b0, 1'b0, 32'h0000_1002},
    '{4'hC, 5'b00000, 5'h08, 3'd0, 1'b1, 1'b0, 32'h0000_1080},
    '{4'h5, 5'b00000, 5'h00, 3'd1, 1'b1, 1'b0, 32'h0000_1002},
    '{4'h5, 5'b00000, 5'h00, 3'd0, 1'b0, 1'b1, 32'h0000_1002},
    '{4'h2, 5'b00000, 5'h00, 3'd0, 1'b0, 1'b0, 32'h0000_1002},
    '{4'h5, 5'b11111, 5'h00, 3'd0, 1'b0, 1'b1, 32'h0000_1002},
    '{4'h5, 5'b00000, 5'h01, 3'd0, 1'b1, 1'b0, 32'h0000_1010},
    '{4'h7, 5'b00001, 5'h01, 3'd0, 1'b1, 1'b0, 32'h0000_1010},
    '{4'h6, 5'b01000, 5'h00, 3'd5, 1'b1, 1'b0, 32'h0000_100A}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [1:0]  req_kind = 2'd0;
  logic [31:0] req_pc = 32'h0000_1000;
  logic [3:0]  req_cc = 4'h0;
  logic [4:0]  req_sdisp_hi = '0;
  logic [2:0]  req_sdisp_lo = '0;
  logic [5:0]  req_ldisp_hi = '0;
  logic [14:0] req_ldisp_lo = '0;
  logic [31:0] req_reg = '0;
  logic        flag_z = 1'b0, flag_s = 1'b0, flag_cy = 1'b0, flag_ov = 1'b0, flag_sat = 1'b0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b1;
  logic [31:0] rsp_next_pc;
  logic        rsp_taken;
  logic [31:0] rsp_link;
  logic        rsp_trap;

  int n_checks = 0;
  int n_fails  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  flow_redirect_unit uut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_kind(req_kind),
    .req_pc(req_pc), .req_cc(req_cc),
    .req_sdisp_hi(req_sdisp_hi), .req_sdisp_lo(req_sdisp_lo),
    .req_ldisp_hi(req_ldisp_hi), .req_ldisp_lo(req_ldisp_lo),
    .req_reg(req_reg),
    .flag_z(flag_z), .flag_s(flag_s), .flag_cy(flag_cy), .flag_ov(flag_ov), .flag_sat(flag_sat),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_next_pc(rsp_next_pc),
    .rsp_taken(rsp_taken), .rsp_link(rsp_link), .rsp_trap(rsp_trap)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // Drive after a falling edge, accepted at the next rising edge, read at the next falling edge.
  task automatic issue(input logic [1:0] kind);
    req_kind  = kind;
    req_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    n_checks++;
    n_fails++;
    $display("FAIL watchdog: actual expired expected completion");
    summary();
  end

  initial begin
    // R10: reset state
    repeat (2) @(negedge clk);
    check("R10 valid", {31'd0, rsp_valid}, 32'd0);
    check("R10 npc", rsp_next_pc, 32'd0);
    check("R10 link", rsp_link, 32'd0);
    check("R10 trap/taken", {30'd0, rsp_trap, rsp_taken}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 ready idle", {31'd0, req_ready}, 32'd1);

    // R3 R4 R5 R6: short branch table
    for (int i = 0; i < NV; i++) begin
      req_pc = 32'h0000_1000;
      req_cc = TBL[i].cc;
      {flag_sat, flag_ov, flag_cy, flag_s, flag_z} = TBL[i].fl;
      req_sdisp_hi = TBL[i].dh;
      req_sdisp_lo = TBL[i].dl;
      issue(2'd0);
      check($sformatf("R1 valid v%0d", i), {31'd0, rsp_valid}, 32'd1);
      check($sformatf("R4 taken v%0d", i), {31'd0, rsp_taken}, {31'd0, TBL[i].tk});
      check($sformatf("R6 trap v%0d", i), {31'd0, rsp_trap}, {31'd0, TBL[i].tr});
      check($sformatf("R5 npc v%0d", i), rsp_next_pc, TBL[i].npc);
      check($sformatf("R5 link v%0d", i), rsp_link, 32'd0);
    end
    {flag_sat, flag_ov, flag_cy, flag_s, flag_z} = 5'b0;

    // R7: long jumps
    req_pc = 32'h0000_1000; req_ldisp_hi = 6'h00; req_ldisp_lo = 15'h0800;
    issue(2'd1);
    check("R7 fwd npc", rsp_next_pc, 32'h0000_2000);
    check("R7 taken", {31'd0, rsp_taken}, 32'd1);
    check("R7 link", rsp_link, 32'd0);
    req_ldisp_hi = 6'h3F; req_ldisp_lo = 15'h7FFF;
    issue(2'd1);
    check("R7 back npc", rsp_next_pc, 32'h0000_0FFE);
    req_ldisp_hi = 6'h20; req_ldisp_lo = 15'h0000;
    issue(2'd1);
    check("R7 sign bit21", rsp_next_pc, 32'hFFE0_1000);

    // R8: jump and link
    req_pc = 32'h0000_2000; req_ldisp_hi = 6'h00; req_ldisp_lo = 15'h0010;
    issue(2'd2);
    check("R8 npc", rsp_next_pc, 32'h0000_2020);
    check("R8 link", rsp_link, 32'h0000_2004);
    check("R8 taken", {31'd0, rsp_taken}, 32'd1);

    // R9: register jump
    req_reg = 32'h1234_5677;
    issue(2'd3);
    check("R9 npc", rsp_next_pc, 32'h1234_5676);
    check("R9 taken", {31'd0, rsp_taken}, 32'd1);
    check("R9 link", rsp_link, 32'd0);

    // R2: back-pressure hold, then release
    @(negedge clk);
    rsp_ready = 1'b0;
    req_reg = 32'h0000_0ABC;
    issue(2'd3);
    check("R2 first npc", rsp_next_pc, 32'h0000_0ABC);
    req_reg = 32'h0000_5550;
    req_kind = 2'd3;
    req_valid = 1'b1;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      check("R2 held valid", {31'd0, rsp_valid}, 32'd1);
      check("R2 held npc", rsp_next_pc, 32'h0000_0ABC);
      check("R1 ready low", {31'd0, req_ready}, 32'd0);
    end
    rsp_ready = 1'b1;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    check("R1 queued npc", rsp_next_pc, 32'h0000_5550);
    check("R1 queued valid", {31'd0, rsp_valid}, 32'd1);
    @(negedge clk);
    check("R1 drained", {31'd0, rsp_valid}, 32'd0);

    // R10: reset in mid-stream clears outputs
    req_pc = 32'h0000_3000; req_ldisp_lo = 15'h0001;
    issue(2'd2);
    rst_n = 1'b0;
    #1;
    check("R10 async valid", {31'd0, rsp_valid}, 32'd0);
    check("R10 async link", rsp_link, 32'd0);
    summary();
  end
endmodule